// File: doc/BRIEF.md
# Event Prescaler Interrupt Generator

This block sits beside a PWM timebase and turns a stream of pre-qualified event strobes into interrupt pulses. Software programs a 2-bit period that says how many events (one, two or three) make up one interrupt. A 2-bit count shows how many events have been seen since the last interrupt. When the count reaches the period, the block emits a single-cycle interrupt pulse, clears the count and sets a status flag.

Interrupts are gated. A pulse is produced only while the enable input is high and the status flag is clear. While the gate is closed, the count climbs to the period and stays there. The interrupt is then delivered as soon as the gate opens, so one interrupt can stay pending while another is serviced.

A software force strobe produces an interrupt directly. A period write takes part in the compare in the cycle it is written, so the new value acts at once.

Top module: `evt_prescale_irq`

## Requirements
- R1: After reset, period_o, count_o and flag_o are 0 and irq_o is low.
- R2: A write (wr_en_i high) loads wr_period_i into period_o at the next edge. With a period of 0, events are not counted (count_o stays put), no pulse is produced and force_i has no effect.
- R3: With period P in 1..3 and the gate open, irq_o is high for exactly one cycle. It rises at the clock edge that closes the cycle carrying the P-th event strobe.
- R4: count_o increments by one for each counted event strobe and reads 0 after every interrupt pulse.
- R5: A pulse is produced only when irq_en_i is high and flag_o is 0 in the cycle that decides it.
- R6: While the gate is closed, count_o stops at the period and holds there instead of wrapping. Once the gate opens with count_o equal to the period, irq_o rises at the next edge without any further event.
- R7: Writing a period equal to the current count produces a pulse at that edge, provided the gate is open.
- R8: An event strobe in the same cycle as a period write (zero or non-zero) is still counted, as long as the count is below the new non-zero period, or the new period is zero. The count never goes past 3.
- R9: flag_o is set at the same edge as each pulse. It stays set until a flag_clr_i strobe clears it at the next edge. If a clear strobe and a new pulse fall in the same cycle, the flag ends up set.
- R10: After a period smaller than the current count is written, count_o holds its value and events produce no pulse.
- R11: With a non-zero period and the gate open, a force_i strobe produces one pulse and clears count_o. With the gate closed, force_i produces nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| evt_i | input | 1 | Pre-qualified timebase event strobe |
| irq_en_i | input | 1 | Interrupt enable level |
| wr_en_i | input | 1 | Period register write strobe |
| wr_period_i | input | 2 | Period write data |
| force_i | input | 1 | Software force strobe |
| flag_clr_i | input | 1 | Status flag clear strobe |
| period_o | output | 2 | Current period field |
| count_o | output | 2 | Current event count field |
| flag_o | output | 1 | Latched interrupt status flag |
| irq_o | output | 1 | Single-cycle interrupt pulse |

## Verification
The count, the flag and the pulse are all registered. A wrong next-state choice therefore shows up on count_o, flag_o or irq_o at the very next edge after the cycle that caused it. A counter that wraps instead of saturating shows as count_o dropping without a pulse. A gate decision that ignores the flag shows as a second pulse before a clear. A late period compare shows as the write-equal-count pulse arriving one cycle late or not at all. The bench sweeps every non-zero period through two full rounds, with the gate open and with it closed. It also walks each write, force and clear collision and compares the ports to expected values one edge later.

// File: rtl/evt_prescale_pkg.sv
package evt_prescale_pkg;

    // Default width of the period and count fields.
    parameter int unsigned FIELD_W_DEF = 2;

    // Registered state of the interrupt gate.
    typedef struct packed {
        logic flag;
        logic irq;
    } gate_state_t;

endpackage

// File: rtl/evt_period_reg.sv
module evt_period_reg #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_period_i,
    output logic [W-1:0] period_q_o,
    output logic [W-1:0] period_eff_o
);

    typedef struct packed {
        logic [W-1:0] period;
    } prd_state_t;

    prd_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (wr_en_i) begin
            state_d.period = wr_period_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign period_q_o   = state_q.period;
    // The value being written this cycle already takes part in the compare.
    assign period_eff_o = state_d.period;

endmodule

// File: rtl/evt_event_counter.sv
module evt_event_counter #(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] period_q_i,
    input  logic [W-1:0] period_eff_i,
    input  logic         fire_i,
    output logic [W-1:0] count_o,
    output logic [W-1:0] cnt_raw_o
);

    localparam logic [W-1:0] CNT_MAX = {W{1'b1}};

    typedef struct packed {
        logic [W-1:0] count;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       at_cap;
    logic       counting;
    logic [W-1:0] raw;

    always_comb begin
        // Stop at a non-zero period; also stop above it when a smaller period was written.
        at_cap   = (period_eff_i != '0) && (state_q.count >= period_eff_i);
        // A zero period halts counting, except in the cycle of a period write.
        counting = evt_i && ((period_q_i != '0) || wr_en_i) && !at_cap
                   && (state_q.count != CNT_MAX);
        raw      = counting ? state_q.count + 1'b1 : state_q.count;

        state_d  = state_q;
        if (fire_i) begin
            state_d.count = '0;
        end else begin
            state_d.count = raw;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign count_o   = state_q.count;
    assign cnt_raw_o = raw;

endmodule

// File: rtl/evt_irq_gate.sv
module evt_irq_gate
    import evt_prescale_pkg::*;
#(
    parameter int unsigned W = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] period_eff_i,
    input  logic [W-1:0] cnt_raw_i,
    input  logic         irq_en_i,
    input  logic         force_i,
    input  logic         flag_clr_i,
    output logic         fire_o,
    output logic         flag_o,
    output logic         irq_o
);

    gate_state_t state_d, state_q;
    logic        gate_open;
    logic        reached;

    always_comb begin
        gate_open = irq_en_i && !state_q.flag;
        reached   = (cnt_raw_i == period_eff_i) || force_i;
        fire_o    = gate_open && (period_eff_i != '0) && reached;

        state_d     = state_q;
        state_d.irq = fire_o;
        if (fire_o) begin
            state_d.flag = 1'b1;       // setting wins over a coincident clear
        end else if (flag_clr_i) begin
            state_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign flag_o = state_q.flag;
    assign irq_o  = state_q.irq;

endmodule

// File: rtl/evt_prescale_irq.sv
module evt_prescale_irq
    import evt_prescale_pkg::*;
#(
    parameter int unsigned W = FIELD_W_DEF
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         evt_i,
    input  logic         irq_en_i,
    input  logic         wr_en_i,
    input  logic [W-1:0] wr_period_i,
    input  logic         force_i,
    input  logic         flag_clr_i,
    output logic [W-1:0] period_o,
    output logic [W-1:0] count_o,
    output logic         flag_o,
    output logic         irq_o
);

    logic [W-1:0] period_q;
    logic [W-1:0] period_eff;
    logic [W-1:0] cnt_raw;
    logic         fire;

    evt_period_reg #(.W(W)) u_period (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en_i      (wr_en_i),
        .wr_period_i  (wr_period_i),
        .period_q_o   (period_q),
        .period_eff_o (period_eff)
    );

    evt_event_counter #(.W(W)) u_counter (
        .clk          (clk),
        .rst_n        (rst_n),
        .evt_i        (evt_i),
        .wr_en_i      (wr_en_i),
        .period_q_i   (period_q),
        .period_eff_i (period_eff),
        .fire_i       (fire),
        .count_o      (count_o),
        .cnt_raw_o    (cnt_raw)
    );

    evt_irq_gate #(.W(W)) u_gate (
        .clk          (clk),
        .rst_n        (rst_n),
        .period_eff_i (period_eff),
        .cnt_raw_i    (cnt_raw),
        .irq_en_i     (irq_en_i),
        .force_i      (force_i),
        .flag_clr_i   (flag_clr_i),
        .fire_o       (fire),
        .flag_o       (flag_o),
        .irq_o        (irq_o)
    );

    assign period_o = period_q;

endmodule

// File: rtl/evt_prescale_irq_chk.sv
module evt_prescale_irq_chk #(
    parameter int unsigned W = 2
) (
    input logic         clk,
    input logic         rst_n,
    input logic         evt_i,
    input logic         irq_en_i,
    input logic         wr_en_i,
    input logic [W-1:0] wr_period_i,
    input logic         force_i,
    input logic         flag_clr_i,
    input logic [W-1:0] period_o,
    input logic [W-1:0] count_o,
    input logic         flag_o,
    input logic         irq_o
);

    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    assert_clear_on_pulse_R4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (count_o == '0));

    assert_gated_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(irq_en_i) && !$past(flag_o)));

    assert_hold_at_period_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && ($past(period_o) != '0) && ($past(count_o) == $past(period_o)))
        |-> ((count_o == $past(count_o)) || irq_o));

    assert_zero_period_quiet_R2: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> ($past(wr_en_i) ? ($past(wr_period_i) != '0) : ($past(period_o) != '0)));

    assert_flag_with_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> flag_o);

    assert_flag_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(flag_o) && !$past(flag_clr_i)) |-> flag_o);

    assert_undefined_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(wr_en_i) && !$past(force_i) && ($past(period_o) != '0)
         && ($past(count_o) > $past(period_o)))
        |-> ((count_o == $past(count_o)) && !irq_o));

endmodule

bind evt_prescale_irq evt_prescale_irq_chk #(.W(W)) u_chk (.*);

// File: tb/test_evt_prescale_irq.sv
module test_evt_prescale_irq;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WDOG_LIMIT = 20000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       evt_i = 1'b0;
    logic       irq_en_i = 1'b0;
    logic       wr_en_i = 1'b0;
    logic [1:0] wr_period_i = 2'd0;
    logic       force_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic [1:0] period_o;
    logic [1:0] count_o;
    logic       flag_o;
    logic       irq_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    evt_prescale_irq i_evt_prescale_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .evt_i       (evt_i),
        .irq_en_i    (irq_en_i),
        .wr_en_i     (wr_en_i),
        .wr_period_i (wr_period_i),
        .force_i     (force_i),
        .flag_clr_i  (flag_clr_i),
        .period_o    (period_o),
        .count_o     (count_o),
        .flag_o      (flag_o),
        .irq_o       (irq_o)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > WDOG_LIMIT) begin
            checks = checks + 1;
            errors = errors + 1;
            $display("FAIL watchdog: actual %0d cycles, expected < %0d", cycles, WDOG_LIMIT);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks = checks + 1;
        if (act != exp) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d, expected %0d", req, act, exp);
        end
    endtask

    task automatic chk_all(input string req, input int p, input int c, input int f, input int q);
        chk({req, " period"}, int'(period_o), p);
        chk({req, " count"},  int'(count_o),  c);
        chk({req, " flag"},   int'(flag_o),   f);
        chk({req, " irq"},    int'(irq_o),    q);
    endtask

    // Drive one cycle of strobes; outputs are sampled 1ns after the edge.
    task automatic cyc(input logic e, input logic w, input logic [1:0] d,
                       input logic frc, input logic clr);
        evt_i = e; wr_en_i = w; wr_period_i = d; force_i = frc; flag_clr_i = clr;
        @(posedge clk);
        #1;
        evt_i = 1'b0; wr_en_i = 1'b0; force_i = 1'b0; flag_clr_i = 1'b0;
    endtask

    initial begin
        #(CLK_PERIOD * 3);
        @(negedge clk);
        chk_all("R1 reset", 0, 0, 0, 0);
        rst_n = 1'b1;
        irq_en_i = 1'b1;
        cyc(0, 0, 2'd0, 0, 0);
        chk_all("R1 after release", 0, 0, 0, 0);

        // R2: zero period, events and force ignored
        for (int k = 0; k < 4; k++) begin
            cyc(1, 0, 2'd0, 0, 0);
            chk_all("R2 zero period event", 0, 0, 0, 0);
        end
        cyc(0, 0, 2'd0, 1, 0);
        chk_all("R2 zero period force", 0, 0, 0, 0);

        // R3/R4: open gate, every period, two rounds each
        for (int p = 1; p <= 3; p++) begin
            cyc(0, 1, 2'(p), 0, 0);
            chk_all("R2 write", p, 0, 0, 0);
            for (int r = 0; r < 2; r++) begin
                for (int e = 1; e <= p; e++) begin
                    cyc(1, 0, 2'd0, 0, 0);
                    chk_all("R3 R4 count", p, (e == p) ? 0 : e, (e == p) ? 1 : 0, (e == p) ? 1 : 0);
                end
                cyc(0, 0, 2'd0, 0, 1);
                chk_all("R9 clear", p, 0, 0, 0);
            end
        end

        // R6/R5: closed gate saturates, pending delivered when gate opens
        for (int p = 1; p <= 3; p++) begin
            cyc(0, 1, 2'(p), 0, 0);
            irq_en_i = 1'b0;
            for (int e = 1; e <= 5; e++) begin
                cyc(1, 0, 2'd0, 0, 0);
                chk_all("R6 R5 disabled saturate", p, (e < p) ? e : p, 0, 0);
            end
            irq_en_i = 1'b1;
            cyc(0, 0, 2'd0, 0, 0);
            chk_all("R6 pending on enable", p, 0, 1, 1);
            for (int e = 1; e <= 5; e++) begin
                cyc(1, 0, 2'd0, 0, 0);
                chk_all("R6 R5 flag saturate", p, (e < p) ? e : p, 1, 0);
            end
            cyc(0, 0, 2'd0, 0, 1);
            chk_all("R9 clear while pending", p, p, 0, 0);
            cyc(0, 0, 2'd0, 0, 0);
            chk_all("R6 pending on clear", p, 0, 1, 1);
            cyc(0, 0, 2'd0, 0, 1);
            chk_all("R3 single cycle", p, 0, 0, 0);
        end

        // R7: write period equal to count
        cyc(0, 1, 2'd3, 0, 0);
        irq_en_i = 1'b0;
        cyc(1, 0, 2'd0, 0, 0);
        cyc(1, 0, 2'd0, 0, 0);
        irq_en_i = 1'b1;
        cyc(0, 0, 2'd0, 0, 0);
        chk_all("R7 before write", 3, 2, 0, 0);
        cyc(0, 1, 2'd2, 0, 0);
        chk_all("R7 write equal", 2, 0, 1, 1);
        cyc(0, 0, 2'd0, 0, 1);

        // R8: write and event in the same cycle
        cyc(0, 1, 2'd3, 0, 0);
        cyc(1, 1, 2'd2, 0, 0);
        chk_all("R8 event with write 2", 2, 1, 0, 0);
        cyc(1, 1, 2'd3, 0, 0);
        chk_all("R8 event with write 3", 3, 2, 0, 0);
        cyc(1, 1, 2'd0, 0, 0);
        chk_all("R8 event with write 0", 0, 3, 0, 0);
        cyc(1, 1, 2'd0, 0, 0);
        chk_all("R8 no wrap past 3", 0, 3, 0, 0);
        cyc(0, 1, 2'd3, 0, 0);
        chk_all("R7 write equal 3", 3, 0, 1, 1);
        cyc(0, 0, 2'd0, 0, 1);

        // R10: period written below count
        cyc(1, 0, 2'd0, 0, 0);
        cyc(1, 0, 2'd0, 0, 0);
        chk_all("R10 setup", 3, 2, 0, 0);
        cyc(0, 1, 2'd1, 0, 0);
        chk_all("R10 smaller write", 1, 2, 0, 0);
        for (int e = 0; e < 3; e++) begin
            cyc(1, 0, 2'd0, 0, 0);
            chk_all("R10 hold", 1, 2, 0, 0);
        end
        cyc(0, 0, 2'd0, 1, 0);
        chk_all("R11 force recovers", 1, 0, 1, 1);
        cyc(0, 0, 2'd0, 0, 1);

        // R11: force with gate open and closed
        cyc(0, 1, 2'd2, 0, 0);
        cyc(1, 0, 2'd0, 0, 0);
        chk_all("R11 setup", 2, 1, 0, 0);
        cyc(0, 0, 2'd0, 1, 0);
        chk_all("R11 force", 2, 0, 1, 1);
        cyc(0, 0, 2'd0, 1, 0);
        chk_all("R11 force with flag", 2, 0, 1, 0);
        cyc(0, 0, 2'd0, 0, 1);
        irq_en_i = 1'b0;
        cyc(0, 0, 2'd0, 1, 0);
        chk_all("R11 force disabled", 2, 0, 0, 0);
        irq_en_i = 1'b1;

        // R9: clear and pulse in the same cycle
        cyc(0, 1, 2'd1, 0, 0);
        cyc(1, 0, 2'd0, 0, 1);
        chk_all("R9 set beats clear", 1, 0, 1, 1);
        cyc(0, 0, 2'd0, 0, 0);
        chk_all("R9 flag stays", 1, 0, 1, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule